// File: doc/BRIEF.md
# Per-Window Endian Lane Translator

This block sits between a big-endian internal bus and a little-endian 32-bit bus data path. Each access carries a direction (initiator or target) and a window number. The block looks up a swap-enable bit for that window and routes the byte lanes, byte enables and low address bits to the bus side. Read data coming back passes through the same mapping, looked up for the window that the response belongs to. There are two independent sets of swap bits. The initiator set is one register with one bit per memory window and one bit for the I/O window. The target set has one control bit per window, and each bit is written on its own.

By default every swap bit is clear, and the block keeps byte addresses consistent: a byte keeps its byte address when it crosses the bus. In big-endian mode this reverses the physical lanes. When a window's swap bit is set in big-endian mode, the block keeps the order of significance instead. A full word then arrives with its most significant byte in the most significant bus lane, and a sub-word access moves to the mirrored byte address. In little-endian mode, data always passes straight through.

Both data channels use valid/ready and contain no storage. `bus_req_valid` follows `req_valid` in the same cycle, and `req_ready` follows `bus_req_ready`. The response channel works the same way in the opposite direction. When the far side lowers ready, the payload must stay stable until the transfer completes. The mode, the swap bits and the window tags must not change during that wait, because the mapping is recomputed in every cycle.

Top module: `endian_win_swapper`

## Requirements
- R1: Request and response channels are zero-latency pass-throughs. `bus_req_valid` equals `req_valid` and `req_ready` equals `bus_req_ready`; `rsp_valid` equals `bus_rsp_valid` and `bus_rsp_ready` equals `rsp_ready`, all in the same cycle.
- R2: With `be_mode`=0 (little-endian), `bus_wdata`, `bus_be` and `bus_addr_lo` equal `req_wdata`, `req_be` and `req_addr`, and `rsp_rdata` equals `bus_rdata`, whatever the swap bits hold.
- R3: With `be_mode`=1 and the selected swap bit 0, the internal byte at address a moves to bus lane a. Internal address a sits in bits [31-8a:24-8a] and bus lane a in bits [8a+7:8a], so the four lanes are reversed. `bus_addr_lo` equals `req_addr`.
- R4: With `be_mode`=1 and the selected swap bit 1, lanes keep their position. For a size of n bytes, `bus_addr_lo` = 4 - n - `req_addr` (mod 4).
- R5: Byte enables follow the same lane mapping as the data. Bit i of `req_be` or `bus_be` qualifies byte lane i, that is bits [8i+7:8i].
- R6: `rsp_rdata` is formed from `bus_rdata` using the same rule as R2–R4. The swap bit is the one selected by `bus_rsp_dir` and `bus_rsp_win`.
- R7: `req_dir`=0 selects the initiator register. `cfg_ini_we` loads all of `cfg_ini_bits` at a clock edge, and the new value takes effect from the next cycle. Bit w (w < NUM_MEM_WIN) controls memory window w, and bit NUM_MEM_WIN controls the I/O window, which has window number NUM_MEM_WIN.
- R8: `req_dir`=1 selects the target bits. `cfg_tgt_we` writes `cfg_tgt_swap` into the bit of window `cfg_tgt_win` only. The other target bits and the whole initiator register stay unchanged.
- R9: While `rst_n` is low, all swap bits are cleared, so after reset every window operates address-consistent.
- R10: `req_size` encodes 0 = byte, 1 = 16-bit, 2 = 32-bit (3 is reserved). A 32-bit access at address 0 always gives `bus_addr_lo` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset of the swap bits |
| be_mode | input | 1 | 1 = internal bus is big-endian |
| cfg_ini_we | input | 1 | Load strobe for the initiator swap register |
| cfg_ini_bits | input | NUM_MEM_WIN+1 | New initiator swap bits (top bit = I/O window) |
| cfg_tgt_we | input | 1 | Write strobe for one target swap bit |
| cfg_tgt_win | input | WIN_W | Window whose target bit is written |
| cfg_tgt_swap | input | 1 | Value for that target bit |
| req_valid | input | 1 | Internal request valid |
| req_ready | output | 1 | Internal request ready |
| req_dir | input | 1 | 0 = initiator, 1 = target |
| req_win | input | WIN_W | Window number (NUM_MEM_WIN = I/O) |
| req_addr | input | AW | Low byte address of the access |
| req_size | input | 2 | Access size code |
| req_wdata | input | 8*LANES | Internal write data |
| req_be | input | LANES | Internal byte enables |
| bus_req_valid | output | 1 | Bus-side request valid |
| bus_req_ready | input | 1 | Bus-side request ready |
| bus_addr_lo | output | AW | Bus low byte address |
| bus_wdata | output | 8*LANES | Bus write data |
| bus_be | output | LANES | Bus byte enables |
| bus_rsp_valid | input | 1 | Bus read data valid |
| bus_rsp_ready | output | 1 | Bus read data ready |
| bus_rsp_dir | input | 1 | Direction of the returning access |
| bus_rsp_win | input | WIN_W | Window of the returning access |
| bus_rdata | input | 8*LANES | Bus read data |
| rsp_valid | output | 1 | Internal read data valid |
| rsp_ready | input | 1 | Internal read data ready |
| rsp_rdata | output | 8*LANES | Translated read data |

## Verification
The bench sets up different initiator and target swap patterns for the same window numbers. A design that indexed the wrong bit set, or that treated the I/O window as a memory window, would then route the lanes the wrong way. Sub-word accesses check that both the byte enables and the low address are mirrored. A design that moved the data but not the enables would write the wrong bus bytes, and one that forgot the address fix would put the address outside the enabled lanes. Further directed tests cover three more cases: the cycle in which a configuration write takes effect, a target write that must leave its neighbours untouched, and a second reset that must restore address-consistent routing.

// File: rtl/swap_pkg.sv
package swap_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_RSVD = 2'd3
  } acc_size_e;

  typedef enum logic {
    DIR_INI = 1'b0,
    DIR_TGT = 1'b1
  } acc_dir_e;
endpackage

// File: rtl/swap_cfg_regs.sv
module swap_cfg_regs #(
  parameter int NUM_WIN = 4,
  parameter int WIN_W   = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ini_we,
  input  logic [NUM_WIN-1:0] ini_bits,
  input  logic               tgt_we,
  input  logic [WIN_W-1:0]   tgt_win,
  input  logic               tgt_swap,
  output logic [NUM_WIN-1:0] ini_q,
  output logic [NUM_WIN-1:0] tgt_q
);
  // initiator set: one register loaded as a whole
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ini_q <= '0;
    else if (ini_we) ini_q <= ini_bits;
  end

  // target set: one bit per window, each in its own control register
  for (genvar w = 0; w < NUM_WIN; w++) begin : g_tgt
    logic hit;
    assign hit = tgt_we && (tgt_win == WIN_W'(w));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) tgt_q[w] <= 1'b0;
      else if (hit) tgt_q[w] <= tgt_swap;
    end
  end
endmodule

// File: rtl/swap_select.sv
module swap_select
  import swap_pkg::*;
#(
  parameter int NUM_WIN = 4,
  parameter int WIN_W   = 2
) (
  input  logic [NUM_WIN-1:0] ini_q,
  input  logic [NUM_WIN-1:0] tgt_q,
  input  logic               be_mode,
  input  logic               dir,
  input  logic [WIN_W-1:0]   win,
  output logic               swap_on
);
  logic [NUM_WIN-1:0] bank;
  logic               bit_sel;

  always_comb begin
    bank    = (acc_dir_e'(dir) == DIR_TGT) ? tgt_q : ini_q;
    bit_sel = 1'b0;
    for (int w = 0; w < NUM_WIN; w++) begin
      if (win == WIN_W'(w)) bit_sel = bank[w];
    end
    swap_on = be_mode & bit_sel;
  end
endmodule

// File: rtl/lane_rev.sv
module lane_rev #(
  parameter int LANES  = 4,
  parameter int LANE_W = 8
) (
  input  logic                    rev,
  input  logic [LANES*LANE_W-1:0] din,
  output logic [LANES*LANE_W-1:0] dout
);
  for (genvar i = 0; i < LANES; i++) begin : g_lane
    localparam int J = LANES - 1 - i;
    assign dout[i*LANE_W +: LANE_W] = rev ? din[J*LANE_W +: LANE_W]
                                          : din[i*LANE_W +: LANE_W];
  end
endmodule

// File: rtl/addr_xlate.sv
module addr_xlate #(
  parameter int LANES = 4,
  parameter int AW    = 2
) (
  input  logic          swap_on,
  input  logic [AW-1:0] addr,
  input  logic [1:0]    size,
  output logic [AW-1:0] addr_out
);
  logic [AW:0] nbytes;
  logic [AW:0] mirrored;

  always_comb begin
    nbytes   = (AW+1)'(1) << size;
    mirrored = (AW+1)'(LANES) - nbytes - {1'b0, addr};
    addr_out = swap_on ? mirrored[AW-1:0] : addr;
  end
endmodule

// File: rtl/endian_win_swapper.sv
module endian_win_swapper #(
  parameter int NUM_MEM_WIN = 3,
  parameter int LANES       = 4,
  localparam int NUM_WIN    = NUM_MEM_WIN + 1,
  localparam int WIN_W      = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1,
  localparam int AW         = $clog2(LANES),
  localparam int DATA_W     = 8 * LANES
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               be_mode,
  input  logic               cfg_ini_we,
  input  logic [NUM_WIN-1:0] cfg_ini_bits,
  input  logic               cfg_tgt_we,
  input  logic [WIN_W-1:0]   cfg_tgt_win,
  input  logic               cfg_tgt_swap,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic               req_dir,
  input  logic [WIN_W-1:0]   req_win,
  input  logic [AW-1:0]      req_addr,
  input  logic [1:0]         req_size,
  input  logic [DATA_W-1:0]  req_wdata,
  input  logic [LANES-1:0]   req_be,
  output logic               bus_req_valid,
  input  logic               bus_req_ready,
  output logic [AW-1:0]      bus_addr_lo,
  output logic [DATA_W-1:0]  bus_wdata,
  output logic [LANES-1:0]   bus_be,
  input  logic               bus_rsp_valid,
  output logic               bus_rsp_ready,
  input  logic               bus_rsp_dir,
  input  logic [WIN_W-1:0]   bus_rsp_win,
  input  logic [DATA_W-1:0]  bus_rdata,
  output logic               rsp_valid,
  input  logic               rsp_ready,
  output logic [DATA_W-1:0]  rsp_rdata
);
  logic [NUM_WIN-1:0] ini_q;
  logic [NUM_WIN-1:0] tgt_q;
  logic               req_swap;
  logic               rsp_swap;
  logic               req_rev;
  logic               rsp_rev;

  swap_cfg_regs #(.NUM_WIN(NUM_WIN), .WIN_W(WIN_W)) u_cfg (
    .clk      (clk),
    .rst_n    (rst_n),
    .ini_we   (cfg_ini_we),
    .ini_bits (cfg_ini_bits),
    .tgt_we   (cfg_tgt_we),
    .tgt_win  (cfg_tgt_win),
    .tgt_swap (cfg_tgt_swap),
    .ini_q    (ini_q),
    .tgt_q    (tgt_q)
  );

  swap_select #(.NUM_WIN(NUM_WIN), .WIN_W(WIN_W)) u_sel_req (
    .ini_q   (ini_q),
    .tgt_q   (tgt_q),
    .be_mode (be_mode),
    .dir     (req_dir),
    .win     (req_win),
    .swap_on (req_swap)
  );

  swap_select #(.NUM_WIN(NUM_WIN), .WIN_W(WIN_W)) u_sel_rsp (
    .ini_q   (ini_q),
    .tgt_q   (tgt_q),
    .be_mode (be_mode),
    .dir     (bus_rsp_dir),
    .win     (bus_rsp_win),
    .swap_on (rsp_swap)
  );

  // big-endian without swap keeps addresses: physical lanes reverse
  assign req_rev = be_mode & ~req_swap;
  assign rsp_rev = be_mode & ~rsp_swap;

  lane_rev #(.LANES(LANES), .LANE_W(8)) u_wdata (
    .rev (req_rev), .din (req_wdata), .dout (bus_wdata)
  );

  lane_rev #(.LANES(LANES), .LANE_W(1)) u_be (
    .rev (req_rev), .din (req_be), .dout (bus_be)
  );

  lane_rev #(.LANES(LANES), .LANE_W(8)) u_rdata (
    .rev (rsp_rev), .din (bus_rdata), .dout (rsp_rdata)
  );

  addr_xlate #(.LANES(LANES), .AW(AW)) u_addr (
    .swap_on  (req_swap),
    .addr     (req_addr),
    .size     (req_size),
    .addr_out (bus_addr_lo)
  );

  // stateless channels: handshake passes straight through
  assign bus_req_valid = req_valid;
  assign req_ready     = bus_req_ready;
  assign rsp_valid     = bus_rsp_valid;
  assign bus_rsp_ready = rsp_ready;
endmodule

// File: rtl/swap_chk.sv
module swap_chk #(
  parameter int LANES = 4,
  parameter int AW    = 2
) (
  input logic               clk,
  input logic               rst_n,
  input logic               be_mode,
  input logic               req_valid,
  input logic               req_ready,
  input logic [AW-1:0]      req_addr,
  input logic [1:0]         req_size,
  input logic [8*LANES-1:0] req_wdata,
  input logic [LANES-1:0]   req_be,
  input logic               bus_req_valid,
  input logic               bus_req_ready,
  input logic [AW-1:0]      bus_addr_lo,
  input logic [8*LANES-1:0] bus_wdata,
  input logic [LANES-1:0]   bus_be,
  input logic               bus_rsp_valid,
  input logic               bus_rsp_ready,
  input logic [8*LANES-1:0] bus_rdata,
  input logic               rsp_valid,
  input logic               rsp_ready,
  input logic [8*LANES-1:0] rsp_rdata
);
  // R1
  handshake_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req_valid == req_valid) && (req_ready == bus_req_ready) &&
    (rsp_valid == bus_rsp_valid) && (bus_rsp_ready == rsp_ready));

  // R2
  le_identity_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!be_mode && req_valid) |->
      (bus_wdata == req_wdata) && (bus_be == req_be) && (bus_addr_lo == req_addr));

  // R5
  be_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> ($countones(bus_be) == $countones(req_be)));

  // R6
  rdata_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rsp_valid |-> ($countones(rsp_rdata) == $countones(bus_rdata)));

  // R10
  word_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_size == 2'd2 && req_addr == '0) |-> (bus_addr_lo == '0));
endmodule

bind endian_win_swapper swap_chk #(.LANES(LANES), .AW(AW)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .be_mode       (be_mode),
  .req_valid     (req_valid),
  .req_ready     (req_ready),
  .req_addr      (req_addr),
  .req_size      (req_size),
  .req_wdata     (req_wdata),
  .req_be        (req_be),
  .bus_req_valid (bus_req_valid),
  .bus_req_ready (bus_req_ready),
  .bus_addr_lo   (bus_addr_lo),
  .bus_wdata     (bus_wdata),
  .bus_be        (bus_be),
  .bus_rsp_valid (bus_rsp_valid),
  .bus_rsp_ready (bus_rsp_ready),
  .bus_rdata     (bus_rdata),
  .rsp_valid     (rsp_valid),
  .rsp_ready     (rsp_ready),
  .rsp_rdata     (rsp_rdata)
);

// File: tb/sim_endian_win_swapper.sv
`timescale 1ns/1ps
module sim_endian_win_swapper;
  localparam logic [31:0] WD  = 32'hA1B2C3D4;
  localparam logic [31:0] WDR = 32'hD4C3B2A1;
  localparam logic [31:0] RD  = 32'h11223344;
  localparam logic [31:0] RDR = 32'h44332211;

  typedef struct packed {
    logic        dir;
    logic [1:0]  win;
    logic        bem;
    logic [1:0]  addr;
    logic [1:0]  size;
    logic [3:0]  be;
    logic [31:0] xw;
    logic [3:0]  xbe;
    logic [1:0]  xa;
    logic [31:0] xr;
    logic [3:0]  rq;
  } vec_t;

  // config during table: initiator bits 0101, target bits 1010
  localparam int NV = 13;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 2'd0, 1'b1, 2'd0, 2'd2, 4'hF, WD,  4'hF, 2'd0, RD,  4'd4},  // R4 word swapped
    '{1'b0, 2'd1, 1'b1, 2'd0, 2'd2, 4'hF, WDR, 4'hF, 2'd0, RDR, 4'd3},  // R3 word addr-consistent
    '{1'b0, 2'd1, 1'b1, 2'd0, 2'd1, 4'hC, WDR, 4'h3, 2'd0, RDR, 4'd5},  // R5 half enables mirrored
    '{1'b0, 2'd2, 1'b1, 2'd0, 2'd1, 4'hC, WD,  4'hC, 2'd2, RD,  4'd4},  // R4 half addr fix
    '{1'b0, 2'd0, 1'b1, 2'd1, 2'd0, 4'h4, WD,  4'h4, 2'd2, RD,  4'd4},  // R4 byte addr fix
    '{1'b0, 2'd3, 1'b1, 2'd3, 2'd0, 4'h1, WDR, 4'h8, 2'd3, RDR, 4'd7},  // R7 I/O bit clear
    '{1'b1, 2'd1, 1'b1, 2'd0, 2'd2, 4'hF, WD,  4'hF, 2'd0, RD,  4'd8},  // R8 target win1 set
    '{1'b1, 2'd0, 1'b1, 2'd0, 2'd2, 4'hF, WDR, 4'hF, 2'd0, RDR, 4'd8},  // R8 independent of initiator
    '{1'b1, 2'd3, 1'b1, 2'd2, 2'd1, 4'h3, WD,  4'h3, 2'd0, RD,  4'd8},  // R8 target I/O half
    '{1'b1, 2'd2, 1'b1, 2'd0, 2'd2, 4'hF, WDR, 4'hF, 2'd0, RDR, 4'd6},  // R6 read mirrored
    '{1'b0, 2'd0, 1'b0, 2'd0, 2'd2, 4'hF, WD,  4'hF, 2'd0, RD,  4'd2},  // R2 LE ignores swap
    '{1'b1, 2'd3, 1'b0, 2'd1, 2'd0, 4'h2, WD,  4'h2, 2'd1, RD,  4'd2},  // R2 LE byte
    '{1'b0, 2'd1, 1'b1, 2'd2, 2'd1, 4'h3, WDR, 4'hC, 2'd2, RDR, 4'd3}   // R3 upper half
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic be_mode = 1'b0;
  logic cfg_ini_we = 1'b0;
  logic [3:0] cfg_ini_bits = '0;
  logic cfg_tgt_we = 1'b0;
  logic [1:0] cfg_tgt_win = '0;
  logic cfg_tgt_swap = 1'b0;
  logic req_valid = 1'b0;
  logic req_ready;
  logic req_dir = 1'b0;
  logic [1:0] req_win = '0;
  logic [1:0] req_addr = '0;
  logic [1:0] req_size = 2'd2;
  logic [31:0] req_wdata = '0;
  logic [3:0] req_be = '0;
  logic bus_req_valid;
  logic bus_req_ready = 1'b0;
  logic [1:0] bus_addr_lo;
  logic [31:0] bus_wdata;
  logic [3:0] bus_be;
  logic bus_rsp_valid = 1'b0;
  logic bus_rsp_ready;
  logic bus_rsp_dir = 1'b0;
  logic [1:0] bus_rsp_win = '0;
  logic [31:0] bus_rdata = '0;
  logic rsp_valid;
  logic rsp_ready = 1'b0;
  logic [31:0] rsp_rdata;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  endian_win_swapper u0 (.*);

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic drive(input logic dir, input logic [1:0] win, input logic bem,
                       input logic [1:0] addr, input logic [1:0] size,
                       input logic [3:0] be);
    @(negedge clk);
    be_mode = bem; req_valid = 1'b1; bus_rsp_valid = 1'b1;
    req_dir = dir; req_win = win; req_addr = addr; req_size = size;
    req_be = be; req_wdata = WD; bus_rsp_dir = dir; bus_rsp_win = win;
    bus_rdata = RD;
    #2;
  endtask

  task automatic ini_write(input logic [3:0] bits);
    @(negedge clk);
    cfg_ini_we = 1'b1; cfg_ini_bits = bits;
    @(posedge clk); #1;
    cfg_ini_we = 1'b0;
  endtask

  task automatic tgt_write(input logic [1:0] win, input logic val);
    @(negedge clk);
    cfg_tgt_we = 1'b1; cfg_tgt_win = win; cfg_tgt_swap = val;
    @(posedge clk); #1;
    cfg_tgt_we = 1'b0;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R9: after reset every window is address-consistent
    drive(1'b0, 2'd0, 1'b1, 2'd0, 2'd2, 4'hF);
    chk("R9", "ini w0 wdata", bus_wdata, WDR);
    drive(1'b1, 2'd3, 1'b1, 2'd0, 2'd2, 4'hF);
    chk("R9", "tgt io rdata", rsp_rdata, RDR);

    // R1: handshake pass-through
    drive(1'b0, 2'd0, 1'b1, 2'd0, 2'd2, 4'hF);
    bus_req_ready = 1'b0; rsp_ready = 1'b0; #1;
    chk("R1", "req_ready low", {31'd0, req_ready}, 32'd0);
    chk("R1", "bus_req_valid", {31'd0, bus_req_valid}, 32'd1);
    chk("R1", "bus_rsp_ready low", {31'd0, bus_rsp_ready}, 32'd0);
    bus_req_ready = 1'b1; rsp_ready = 1'b1; #1;
    chk("R1", "req_ready high", {31'd0, req_ready}, 32'd1);
    chk("R1", "rsp_valid", {31'd0, rsp_valid}, 32'd1);
    chk("R1", "bus_rsp_ready high", {31'd0, bus_rsp_ready}, 32'd1);
    req_valid = 1'b0; bus_rsp_valid = 1'b0; #1;
    chk("R1", "bus_req_valid low", {31'd0, bus_req_valid}, 32'd0);

    // R7: initiator load takes effect only after the edge
    drive(1'b0, 2'd0, 1'b1, 2'd0, 2'd2, 4'hF);
    cfg_ini_we = 1'b1; cfg_ini_bits = 4'b0101; #1;
    chk("R7", "before edge", bus_wdata, WDR);
    @(posedge clk); #1;
    cfg_ini_we = 1'b0;
    chk("R7", "after edge", bus_wdata, WD);

    tgt_write(2'd1, 1'b1);
    tgt_write(2'd3, 1'b1);

    // table walk
    for (int i = 0; i < NV; i++) begin
      string tag;
      tag = $sformatf("R%0d", VECS[i].rq);
      drive(VECS[i].dir, VECS[i].win, VECS[i].bem, VECS[i].addr,
            VECS[i].size, VECS[i].be);
      chk(tag, $sformatf("v%0d wdata", i), bus_wdata, VECS[i].xw);
      chk(tag, $sformatf("v%0d be", i), {28'd0, bus_be}, {28'd0, VECS[i].xbe});
      chk(tag, $sformatf("v%0d addr", i), {30'd0, bus_addr_lo}, {30'd0, VECS[i].xa});
      chk(tag, $sformatf("v%0d rdata", i), rsp_rdata, VECS[i].xr);
    end

    // R8: clearing one target bit leaves its neighbours and initiator alone
    tgt_write(2'd1, 1'b0);
    drive(1'b1, 2'd1, 1'b1, 2'd0, 2'd2, 4'hF);
    chk("R8", "tgt w1 cleared", bus_wdata, WDR);
    drive(1'b1, 2'd3, 1'b1, 2'd0, 2'd2, 4'hF);
    chk("R8", "tgt io kept", bus_wdata, WD);
    drive(1'b0, 2'd2, 1'b1, 2'd0, 2'd2, 4'hF);
    chk("R8", "ini w2 kept", bus_wdata, WD);

    // R6: response window chosen independently of request window
    drive(1'b0, 2'd1, 1'b1, 2'd0, 2'd2, 4'hF);
    bus_rsp_dir = 1'b1; bus_rsp_win = 2'd3; #1;
    chk("R6", "rsp own window", rsp_rdata, RD);
    chk("R6", "req own window", bus_wdata, WDR);

    // R9: second reset clears everything
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    drive(1'b0, 2'd0, 1'b1, 2'd0, 2'd2, 4'hF);
    chk("R9", "ini after reset", bus_wdata, WDR);
    drive(1'b1, 2'd3, 1'b1, 2'd0, 2'd1, 4'hC);
    chk("R9", "tgt be after reset", {28'd0, bus_be}, 32'h3);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule